// File: doc/BRIEF.md
# Sector Bit-Flip Corrector for 8-Error BCH Reports

This block sits behind a BCH decoder that handles one 512-byte sector at a time. For each sector the decoder reports how many bit errors it found and up to eight 13-bit error offsets. The offsets are packed back to back into a 104-bit field: three 32-bit words followed by one byte taken from the status word. The block accepts one report at a time and captures it. It then walks the offsets in index order. Each offset has its two low bits inverted to give the data bit ordering. An offset that falls beyond the sector is dropped. Every other offset becomes a bit-flip command made of a byte address and a one-hot bit mask, which goes to an external sector buffer.

The report arrives on a valid/ready port. `rpt_ready` is high only while the block is idle. A report is taken on the rising edge where both `rpt_valid` and `rpt_ready` are high, and once it is taken the block ignores that port until it has finished. Flip commands leave on a second valid/ready port. The buffer may hold `flip_ready` low for as long as it needs. While it does, the pending command stays on the port unchanged and the walk stops. Each sector ends with a one-cycle `done` pulse. The pulse carries the number of flips applied, or a fail flag when the error count is more than the decoder can fix.

Top module: `sector_bitfix`

## Requirements
- R1: `rpt_ready` is high when idle, including straight after reset. It goes low from the cycle after a report is accepted until the cycle after `done`. While it is low, activity on the report port has no effect on the flips or the result.
- R2: The error count is the 4-bit field `rpt_stat[13:10]`. Only this field and `rpt_stat[23:16]` are used. All other status bits are ignored.
- R3: An error count of 0 gives `done` in the cycle after acceptance, with `done_count` = 0 and `done_fail` = 0. No flip is issued.
- R4: An error count from 9 to 15 gives `done` in the cycle after acceptance, with `done_fail` = 1 and `done_count` = 0. No flip is issued.
- R5: Raw location i (i = 0..7) is bits [13i+12 : 13i] of the 104-bit value {`rpt_stat[23:16]`, `rpt_hi`, `rpt_mid`, `rpt_lo`}. Bit 0 of that value is `rpt_lo[0]`.
- R6: The adjusted location is the raw location XOR 3. A flip command carries `flip_byte` = adjusted[12:3] and `flip_mask` = 1 << adjusted[2:0].
- R7: An adjusted location above 4096 is skipped. It takes one cycle, raises no `flip_valid` and is not counted. A location of exactly 4096 is applied, as byte 512 with mask 0x01.
- R8: Locations are processed from index 0 upward. Exactly as many are processed as the error count gives. The first one is handled in the cycle after acceptance, and when nothing stalls one location is handled per cycle.
- R9: While `flip_valid` is high and `flip_ready` is low, the command is held with `flip_byte` and `flip_mask` stable, and the walk does not advance.
- R10: `done` is a one-cycle pulse. It comes in the cycle after the last location is handled, with `done_count` equal to the number of flips accepted (0 to 8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rpt_valid | input | 1 | Report offered |
| rpt_ready | output | 1 | Block idle and able to take a report |
| rpt_lo | input | 32 | Packed location bits 31..0 |
| rpt_mid | input | 32 | Packed location bits 63..32 |
| rpt_hi | input | 32 | Packed location bits 95..64 |
| rpt_stat | input | 32 | Status word: error count in [13:10], location bits 103..96 in [23:16] |
| flip_valid | output | 1 | Flip command offered |
| flip_ready | input | 1 | Sector buffer takes the command |
| flip_byte | output | 10 | Byte address inside the sector |
| flip_mask | output | 8 | One-hot mask of the bit to invert |
| done | output | 1 | One-cycle end-of-sector pulse |
| done_count | output | 4 | Flips applied, valid with `done` |
| done_fail | output | 1 | Sector uncorrectable, valid with `done` |

## Verification
If a report is accepted at rising edge N, its first location appears on the flip port after edge N+1. After that, each further location appears one edge later, or later still for every edge on which `flip_ready` was low. `done` appears one edge after the last location is handled. For a count of 0 or more than 8, this is the edge right after acceptance. The bench advances a queue-based reference model on each rising edge using the inputs present at that edge. At every falling edge it compares each output against the model, so each result is checked in exactly the cycle it is due.

// File: rtl/bfx_pkg.sv
package bfx_pkg;

  localparam int BFX_WORD_W      = 32;
  localparam int BFX_LOC_W       = 13;
  localparam int BFX_NUM_LOCS    = 8;
  localparam int BFX_CNT_W       = 4;
  localparam int BFX_CNT_LSB     = 10;
  localparam int BFX_SPILL_LSB   = 16;
  localparam int BFX_SECTOR_BITS = 4096;
  localparam int BFX_MASK_W      = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1,
    ST_FIN  = 2'd2
  } walk_state_e;

endpackage

// File: rtl/bfx_unpack.sv
module bfx_unpack #(
  parameter int WORD_W   = 32,
  parameter int LOC_W    = 13,
  parameter int NUM_LOCS = 8,
  localparam int PACK_W  = LOC_W * NUM_LOCS,
  localparam int SPILL_W = PACK_W - 3 * WORD_W,
  localparam int IDX_W   = $clog2(NUM_LOCS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [WORD_W-1:0]  w_lo,
  input  logic [WORD_W-1:0]  w_mid,
  input  logic [WORD_W-1:0]  w_hi,
  input  logic [SPILL_W-1:0] spill,
  input  logic [IDX_W-1:0]   sel,
  output logic [LOC_W-1:0]   loc_adj
);

  // Captured report, bit 0 is the lowest bit of the first word (R5)
  logic [PACK_W-1:0] pack_q;
  logic [LOC_W-1:0]  locs [NUM_LOCS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pack_q <= '0;
    end else if (load) begin
      pack_q <= {spill, w_hi, w_mid, w_lo};
    end
  end

  // Each field is a contiguous slice; the two low bits are inverted to reach
  // data bit ordering (R6)
  for (genvar gi = 0; gi < NUM_LOCS; gi++) begin : g_loc
    assign locs[gi] = pack_q[gi*LOC_W +: LOC_W] ^ LOC_W'(3);
  end

  assign loc_adj = locs[sel];

endmodule

// File: rtl/bfx_flipfmt.sv
module bfx_flipfmt #(
  parameter int LOC_W       = 13,
  parameter int SECTOR_BITS = 4096,
  parameter int MASK_W      = 8,
  localparam int SHIFT_W    = $clog2(MASK_W),
  localparam int BYTE_W     = LOC_W - SHIFT_W
) (
  input  logic [LOC_W-1:0]  loc,
  output logic              in_range,
  output logic [BYTE_W-1:0] byte_addr,
  output logic [MASK_W-1:0] bit_mask
);

  // Inclusive limit: an offset equal to the sector size still counts (R7)
  assign in_range  = loc <= LOC_W'(SECTOR_BITS);
  assign byte_addr = loc[LOC_W-1:SHIFT_W];
  assign bit_mask  = MASK_W'(1) << loc[SHIFT_W-1:0];

endmodule

// File: rtl/bfx_walker.sv
module bfx_walker
  import bfx_pkg::*;
#(
  parameter int NUM_LOCS = 8,
  parameter int CNT_W    = 4,
  localparam int IDX_W   = $clog2(NUM_LOCS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] start_cnt,
  input  logic             loc_ok,
  input  logic             flip_ready,
  output logic             idle,
  output logic [IDX_W-1:0] sel,
  output logic             flip_valid,
  output logic             done,
  output logic [CNT_W-1:0] done_count,
  output logic             done_fail
);

  walk_state_e      st_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] app_q;
  logic             fail_q;

  logic cnt_none;
  logic cnt_bad;
  logic step_go;
  logic last_step;

  assign cnt_none  = start_cnt == '0;
  assign cnt_bad   = start_cnt > CNT_W'(NUM_LOCS);
  // A skipped location advances at once; an applied one waits for the buffer
  assign step_go   = (st_q == ST_WALK) && (!loc_ok || flip_ready);
  assign last_step = (CNT_W'(idx_q) + CNT_W'(1)) == cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      cnt_q  <= '0;
      app_q  <= '0;
      fail_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            idx_q  <= '0;
            cnt_q  <= start_cnt;
            app_q  <= '0;
            fail_q <= cnt_bad;
            st_q   <= (cnt_none || cnt_bad) ? ST_FIN : ST_WALK;
          end
        end
        ST_WALK: begin
          if (step_go) begin
            idx_q <= idx_q + 1'b1;
            if (loc_ok) app_q <= app_q + 1'b1;
            if (last_step) st_q <= ST_FIN;
          end
        end
        ST_FIN:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign idle       = st_q == ST_IDLE;
  assign sel        = idx_q;
  assign flip_valid = (st_q == ST_WALK) && loc_ok;
  assign done       = st_q == ST_FIN;
  assign done_count = app_q;
  assign done_fail  = fail_q;

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (!flip_valid && !done));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_count_max_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_count <= CNT_W'(NUM_LOCS)));

  p_fail_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_fail) |-> (done_count == '0));

  p_start_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (cnt_none || cnt_bad)) |=> (done && !flip_valid));

endmodule

// File: rtl/sector_bitfix.sv
module sector_bitfix
  import bfx_pkg::*;
#(
  parameter int WORD_W      = BFX_WORD_W,
  parameter int LOC_W       = BFX_LOC_W,
  parameter int NUM_LOCS    = BFX_NUM_LOCS,
  parameter int CNT_W       = BFX_CNT_W,
  parameter int CNT_LSB     = BFX_CNT_LSB,
  parameter int SPILL_LSB   = BFX_SPILL_LSB,
  parameter int SECTOR_BITS = BFX_SECTOR_BITS,
  parameter int MASK_W      = BFX_MASK_W,
  localparam int SPILL_W    = LOC_W * NUM_LOCS - 3 * WORD_W,
  localparam int BYTE_W     = LOC_W - $clog2(MASK_W),
  localparam int IDX_W      = $clog2(NUM_LOCS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rpt_valid,
  output logic              rpt_ready,
  input  logic [WORD_W-1:0] rpt_lo,
  input  logic [WORD_W-1:0] rpt_mid,
  input  logic [WORD_W-1:0] rpt_hi,
  input  logic [WORD_W-1:0] rpt_stat,
  output logic              flip_valid,
  input  logic              flip_ready,
  output logic [BYTE_W-1:0] flip_byte,
  output logic [MASK_W-1:0] flip_mask,
  output logic              done,
  output logic [CNT_W-1:0]  done_count,
  output logic              done_fail
);

  logic             accept;
  logic [CNT_W-1:0] err_cnt;
  logic [IDX_W-1:0] sel;
  logic [LOC_W-1:0] loc_adj;
  logic             loc_ok;
  logic             stat_unused;

  assign accept  = rpt_valid && rpt_ready;
  assign err_cnt = rpt_stat[CNT_LSB +: CNT_W];   // R2
  assign stat_unused = ^rpt_stat;

  bfx_unpack #(
    .WORD_W  (WORD_W),
    .LOC_W   (LOC_W),
    .NUM_LOCS(NUM_LOCS)
  ) u_unpack (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .w_lo   (rpt_lo),
    .w_mid  (rpt_mid),
    .w_hi   (rpt_hi),
    .spill  (rpt_stat[SPILL_LSB +: SPILL_W]),
    .sel    (sel),
    .loc_adj(loc_adj)
  );

  bfx_flipfmt #(
    .LOC_W      (LOC_W),
    .SECTOR_BITS(SECTOR_BITS),
    .MASK_W     (MASK_W)
  ) u_fmt (
    .loc      (loc_adj),
    .in_range (loc_ok),
    .byte_addr(flip_byte),
    .bit_mask (flip_mask)
  );

  bfx_walker #(
    .NUM_LOCS(NUM_LOCS),
    .CNT_W   (CNT_W)
  ) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .start_cnt (err_cnt),
    .loc_ok    (loc_ok),
    .flip_ready(flip_ready),
    .idle      (rpt_ready),
    .sel       (sel),
    .flip_valid(flip_valid),
    .done      (done),
    .done_count(done_count),
    .done_fail (done_fail)
  );

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flip_valid && !flip_ready) |=>
      (flip_valid && $stable(flip_byte) && $stable(flip_mask)));

  p_mask_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flip_valid |-> ($countones(flip_mask) == 1));

  p_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flip_valid |-> (flip_byte <= BYTE_W'(SECTOR_BITS / MASK_W)));

  p_busy_closed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept) |=> !rpt_ready);

endmodule

// File: tb/sector_bitfix_test.sv
`timescale 1ns/1ps
module sector_bitfix_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rpt_valid = 1'b0;
  logic        rpt_ready;
  logic [31:0] rpt_lo = '0, rpt_mid = '0, rpt_hi = '0, rpt_stat = '0;
  logic        flip_valid;
  logic        flip_ready = 1'b1;
  logic [9:0]  flip_byte;
  logic [7:0]  flip_mask;
  logic        done;
  logic [3:0]  done_count;
  logic        done_fail;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit bp_mode = 1'b0;
  string scen = "R1";
  int unsigned lcg = 32'h1234_5678;

  always #4 clk = ~clk;

  sector_bitfix uut (
    .clk(clk), .rst_n(rst_n),
    .rpt_valid(rpt_valid), .rpt_ready(rpt_ready),
    .rpt_lo(rpt_lo), .rpt_mid(rpt_mid), .rpt_hi(rpt_hi), .rpt_stat(rpt_stat),
    .flip_valid(flip_valid), .flip_ready(flip_ready),
    .flip_byte(flip_byte), .flip_mask(flip_mask),
    .done(done), .done_count(done_count), .done_fail(done_fail)
  );

  // ---------------- reference model ----------------
  int m_phase = 0;      // 0 idle, 1 walking, 2 finishing
  int m_q[$];           // adjusted locations still to handle
  int m_applied = 0;
  bit m_fail = 1'b0;

  function automatic int raw_loc(input logic [31:0] lo, mid, hi, st, input int i);
    int v = 0;
    for (int b = 0; b < 13; b++) begin
      int k = 13 * i + b;
      logic bitv;
      if (k < 32)      bitv = lo[k];
      else if (k < 64) bitv = mid[k-32];
      else if (k < 96) bitv = hi[k-64];
      else             bitv = st[16 + k - 96];
      v |= int'(bitv) << b;
    end
    return v;
  endfunction

  always @(posedge clk) begin
    int c;
    if (!rst_n) begin
      m_phase = 0; m_q.delete(); m_applied = 0; m_fail = 1'b0;
    end else begin
      case (m_phase)
        0: if (rpt_valid) begin
             c = int'(rpt_stat[13:10]);
             m_applied = 0;
             m_fail = (c > 8);
             m_q.delete();
             if (c == 0 || c > 8) m_phase = 2;
             else begin
               for (int i = 0; i < c; i++)
                 m_q.push_back(raw_loc(rpt_lo, rpt_mid, rpt_hi, rpt_stat, i) ^ 3);
               m_phase = 1;
             end
           end
        1: if (m_q[0] > 4096 || flip_ready) begin
             if (m_q[0] <= 4096) m_applied++;
             void'(m_q.pop_front());
             if (m_q.size() == 0) m_phase = 2;
           end
        default: m_phase = 0;
      endcase
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s [%s] %s: actual %0d expected %0d at cycle %0d",
               req, scen, what, act, exp, cyc);
    end
  endtask

  // Compare on the falling edge, then drive back-pressure for the next edge
  always @(negedge clk) begin
    bit e_ready, e_fv;
    cyc++;
    e_ready = (m_phase == 0);
    e_fv    = (m_phase == 1) && (m_q[0] <= 4096);
    check(rpt_ready == e_ready, "R1", "rpt_ready", int'(rpt_ready), int'(e_ready));
    check(flip_valid == e_fv, "R8", "flip_valid", int'(flip_valid), int'(e_fv));
    if (e_fv) begin
      check(flip_byte == 10'(m_q[0] >> 3), "R6", "flip_byte",
            int'(flip_byte), m_q[0] >> 3);
      check(flip_mask == 8'(1 << (m_q[0] & 7)), "R6", "flip_mask",
            int'(flip_mask), 1 << (m_q[0] & 7));
    end
    check(done == (m_phase == 2), "R10", "done", int'(done), int'(m_phase == 2));
    if (m_phase == 2) begin
      check(done_count == 4'(m_applied), "R10", "done_count",
            int'(done_count), m_applied);
      check(done_fail == m_fail, "R4", "done_fail", int'(done_fail), int'(m_fail));
    end
    flip_ready = !bp_mode || (cyc % 3 == 0);
    if (cyc > 60000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  function automatic int unsigned rnd();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return lcg >> 8;
  endfunction

  task automatic pack(input int adj[8], input int cnt, input logic [31:0] noise);
    logic [31:0] lo = '0, mid = '0, hi = '0, st;
    st = noise;
    st[13:10] = 4'(cnt);
    st[23:16] = '0;
    for (int i = 0; i < 8; i++) begin
      int r = adj[i] ^ 3;
      for (int b = 0; b < 13; b++) begin
        int k = 13 * i + b;
        logic bv = r[b];
        if (k < 32)      lo[k] = bv;
        else if (k < 64) mid[k-32] = bv;
        else if (k < 96) hi[k-64] = bv;
        else             st[16 + k - 96] = bv;
      end
    end
    rpt_lo = lo; rpt_mid = mid; rpt_hi = hi; rpt_stat = st;
  endtask

  task automatic send(input int adj[8], input int cnt, input logic [31:0] noise,
                      input bit hold_busy);
    @(negedge clk);
    while (!rpt_ready) @(negedge clk);
    pack(adj, cnt, noise);
    rpt_valid = 1'b1;
    @(negedge clk);
    if (hold_busy) begin
      // R1: junk offered while busy must not disturb anything
      rpt_lo = 32'hFFFF_FFFF; rpt_mid = 32'h0; rpt_hi = 32'h5555_AAAA;
      rpt_stat = 32'h0000_0400;
    end else rpt_valid = 1'b0;
    while (!done) @(negedge clk);
    rpt_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int a[8];
    repeat (3) @(negedge clk);
    scen = "R1";
    check(rpt_ready == 1'b1, "R1", "reset ready", int'(rpt_ready), 1);
    check(done == 1'b0, "R1", "reset done", int'(done), 0);
    rst_n = 1'b1;

    scen = "R3";                         // zero count, noisy status
    a = '{5, 6, 7, 8, 9, 10, 11, 12};
    send(a, 0, 32'hFF00_C3FF, 1'b0);

    scen = "R4";                         // smallest and largest uncorrectable count
    send(a, 9, 32'h0, 1'b0);
    send(a, 15, 32'h0, 1'b0);

    scen = "R5";                         // full eight in-range offsets
    a = '{0, 13, 511, 1000, 2047, 3333, 4000, 4095};
    send(a, 8, 32'h0, 1'b0);

    scen = "R7";                         // range limit either side of 4096
    a = '{4096, 4097, 8191, 0, 4095, 1, 2, 3};
    send(a, 5, 32'h0, 1'b0);

    scen = "R9";                         // back-pressure and busy-time junk
    bp_mode = 1'b1;
    a = '{100, 200, 300, 4500, 400, 500, 600, 700};
    send(a, 8, 32'h0, 1'b1);
    bp_mode = 1'b0;

    scen = "R2";                         // partial count, every other status bit set
    a = '{17, 34, 51, 68, 85, 102, 119, 136};
    send(a, 3, 32'hFF00_C3FF, 1'b0);

    scen = "R8";                         // randomised reports
    for (int n = 0; n < 40; n++) begin
      for (int i = 0; i < 8; i++) a[i] = int'(rnd() % 8192);
      bp_mode = rnd()[0];
      send(a, int'(rnd() % 16), rnd(), rnd()[1]);
    end
    bp_mode = 1'b0;
    repeat (4) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule